// File: doc/BRIEF.md
# Parallel Ring-Oscillator Difference Meter

This block measures many free-running oscillator signals in parallel and reports how each one differs from its neighbour. A single start pulse opens one gate window of fixed length, measured in system-clock cycles. Every oscillator drives its own edge counter, and each counter runs in that oscillator's clock domain. All the counters see the same gate level, so every count covers the same interval.

When the window closes, the counts are left to settle. They are then captured in the system domain, and the block computes signed differences between oscillators that sit side by side. Differences remove the frequency shift that is common to the whole die and keep only the local mismatch. The full set of differences is presented together with a one-cycle valid strobe, and it stays on the outputs until the next measurement completes.

A typical use is a fingerprint source. The default has 32 oscillators, a 20 ms window and 24-bit differences.

Top module: `osc_diff_meter`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is low and every difference field reads zero.
- R2: A `start_i` high on a clock edge where no measurement runs begins a measurement. `valid_o` then rises exactly 2*SETTLE_CYCLES+GATE_CYCLES+2 clock edges after that edge.
- R3: `valid_o` is high for exactly one clock cycle per measurement.
- R4: Field k of `diff_o` (bits k*DIFF_W up to k*DIFF_W+DIFF_W-1) holds count k minus count k+1 as a two's-complement value. It is negative when oscillator k+1 is faster.
- R5: Each count is the number of rising oscillator edges inside one shared window of GATE_CYCLES system cycles. Each reported difference lies within 2 of (window time/period k − window time/period k+1).
- R6: All counters clear at the start of every measurement, so a repeated measurement gives the same differences and does not add to the previous counts.
- R7: A `start_i` pulse that arrives while a measurement runs is ignored. The valid timing and the results of the running measurement are unchanged.
- R8: `diff_o` changes only on the clock edge on which `valid_o` rises. At all other times it holds the last result.
- R9: A `start_i` during the cycle in which `valid_o` is high is accepted as a new measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begins a measurement when idle |
| osc_i | input | NUM_OSC | Free-running oscillator signals, one per counter |
| diff_o | output | (NUM_OSC-1)*DIFF_W | Packed signed adjacent differences, field k = count k − count k+1 |
| valid_o | output | 1 | One-cycle strobe when a new difference set is on `diff_o` |

## Verification
Two events can fall in the same cycle: the completion strobe of one measurement and the acceptance of the next start, since the controller is already idle while `valid_o` is high. The bench provokes this by raising `start_i` exactly in the valid cycle. A behavioural per-cycle model predicts that the new run is accepted. The bench then requires the second strobe to arrive one full run length later and its differences to be correct. A start pulse in the middle of a gate window is also injected, and the model requires both the timing and the values to stay as they were.

// File: rtl/osc_diff_pkg.sv
package osc_diff_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CLEAR   = 3'd1,
    ST_GATE    = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_CAPTURE = 3'd4,
    ST_DIFF    = 3'd5
  } meas_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/osc_diff_ctrl.sv
module osc_diff_ctrl
  import osc_diff_pkg::*;
#(
  parameter int unsigned GATE_CYCLES   = 2500000,
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic gate_o,
  output logic clr_o,
  output logic capture_o,
  output logic load_o,
  output logic busy_o,
  output logic valid_o
);

  localparam int unsigned LONGEST = max2(GATE_CYCLES, SETTLE_CYCLES);
  localparam int unsigned TMR_W   = $clog2(LONGEST + 1);
  typedef logic [TMR_W-1:0] tmr_t;
  localparam tmr_t GATE_LAST   = tmr_t'(GATE_CYCLES - 1);
  localparam tmr_t SETTLE_LAST = tmr_t'(SETTLE_CYCLES - 1);

  meas_state_e state_q, state_d;
  tmr_t        tmr_q, tmr_d;
  logic        gate_q, clr_q, valid_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_CLEAR;
          tmr_d   = '0;
        end
      end
      ST_CLEAR: begin
        if (tmr_q == SETTLE_LAST) begin
          state_d = ST_GATE;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + tmr_t'(1);
        end
      end
      ST_GATE: begin
        if (tmr_q == GATE_LAST) begin
          state_d = ST_SETTLE;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + tmr_t'(1);
        end
      end
      ST_SETTLE: begin
        if (tmr_q == SETTLE_LAST) begin
          state_d = ST_CAPTURE;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + tmr_t'(1);
        end
      end
      ST_CAPTURE: state_d = ST_DIFF;
      ST_DIFF:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // registers; gate and clear are flop outputs so they cross domains glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      gate_q  <= 1'b0;
      clr_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      gate_q  <= (state_d == ST_GATE);
      clr_q   <= (state_d == ST_CLEAR);
      valid_q <= (state_q == ST_DIFF);
    end
  end

  assign gate_o    = gate_q;
  assign clr_o     = clr_q;
  assign capture_o = (state_q == ST_CAPTURE);
  assign load_o    = (state_q == ST_DIFF);
  assign busy_o    = (state_q != ST_IDLE);
  assign valid_o   = valid_q;

endmodule

// File: rtl/osc_diff_counter.sv
module osc_diff_counter #(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic [SYNC_STAGES-1:0] gate_pipe;
  logic [SYNC_STAGES-1:0] clr_pipe;
  logic                   loc_rst_n;
  logic                   gate_s, clr_s;
  logic                   cnt_en;
  logic [CNT_W-1:0]       cnt_q, cnt_d;

  // local reset: asserted asynchronously, released on the oscillator clock
  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign loc_rst_n = rst_pipe[SYNC_STAGES-1];

  // level synchronisers for the shared gate and clear
  always_ff @(posedge osc_clk_i or negedge loc_rst_n) begin
    if (!loc_rst_n) begin
      gate_pipe <= '0;
      clr_pipe  <= '0;
    end else begin
      gate_pipe <= {gate_pipe[SYNC_STAGES-2:0], gate_i};
      clr_pipe  <= {clr_pipe[SYNC_STAGES-2:0], clr_i};
    end
  end
  assign gate_s = gate_pipe[SYNC_STAGES-1];
  assign clr_s  = clr_pipe[SYNC_STAGES-1];

  always_comb begin
    cnt_en = clr_s | gate_s;
    cnt_d  = clr_s ? '0 : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge osc_clk_i or negedge loc_rst_n) begin
    if (!loc_rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/osc_diff_stage.sv
module osc_diff_stage #(
  parameter int unsigned NUM_OSC = 32,
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned DIFF_W  = 24
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            capture_i,
  input  logic                            load_i,
  input  logic [NUM_OSC*CNT_W-1:0]        counts_i,
  output logic [(NUM_OSC-1)*DIFF_W-1:0]   diff_o
);

  localparam int unsigned NUM_DIFF = NUM_OSC - 1;
  localparam int unsigned SUB_W    = CNT_W + 1;

  logic [CNT_W-1:0] cap_q [NUM_OSC];

  // capture of quasi-static counts into the system domain
  for (genvar i = 0; i < NUM_OSC; i++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_q[i] <= '0;
      end else if (capture_i) begin
        cap_q[i] <= counts_i[i*CNT_W +: CNT_W];
      end
    end
  end

  // registered subtraction stage
  for (genvar k = 0; k < NUM_DIFF; k++) begin : g_sub
    logic [SUB_W-1:0]  sub;
    logic [DIFF_W-1:0] dnext;
    logic [DIFF_W-1:0] diff_q;

    assign sub = {1'b0, cap_q[k]} - {1'b0, cap_q[k+1]};

    if (DIFF_W <= SUB_W) begin : g_trunc
      assign dnext = sub[DIFF_W-1:0];
    end else begin : g_sext
      assign dnext = {{(DIFF_W-SUB_W){sub[SUB_W-1]}}, sub};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        diff_q <= '0;
      end else if (load_i) begin
        diff_q <= dnext;
      end
    end

    assign diff_o[k*DIFF_W +: DIFF_W] = diff_q;
  end

endmodule

// File: rtl/osc_diff_meter.sv
module osc_diff_meter #(
  parameter int unsigned NUM_OSC       = 32,
  parameter int unsigned CNT_W         = 24,
  parameter int unsigned DIFF_W        = 24,
  parameter int unsigned GATE_CYCLES   = 2500000,
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [NUM_OSC-1:0]            osc_i,
  output logic [(NUM_OSC-1)*DIFF_W-1:0] diff_o,
  output logic                          valid_o
);

  logic [1:0]               rst_pipe;
  logic                     rst_sys_n;
  logic                     gate_en, clr_en, capture_en, load_en, busy;
  logic [NUM_OSC*CNT_W-1:0] counts;

  // system-domain reset: asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sys_n = rst_pipe[1];

  osc_diff_ctrl #(
    .GATE_CYCLES  (GATE_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_sys_n),
    .start_i  (start_i),
    .gate_o   (gate_en),
    .clr_o    (clr_en),
    .capture_o(capture_en),
    .load_o   (load_en),
    .busy_o   (busy),
    .valid_o  (valid_o)
  );

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_cnt
    osc_diff_counter #(
      .CNT_W      (CNT_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_cnt (
      .osc_clk_i(osc_i[i]),
      .rst_ni   (rst_ni),
      .gate_i   (gate_en),
      .clr_i    (clr_en),
      .count_o  (counts[i*CNT_W +: CNT_W])
    );
  end

  osc_diff_stage #(
    .NUM_OSC(NUM_OSC),
    .CNT_W  (CNT_W),
    .DIFF_W (DIFF_W)
  ) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_sys_n),
    .capture_i(capture_en),
    .load_i   (load_en),
    .counts_i (counts),
    .diff_o   (diff_o)
  );

endmodule

// File: rtl/osc_diff_meter_chk.sv
module osc_diff_meter_chk #(
  parameter int unsigned RUN_CYCLES = 34,
  parameter int unsigned DATA_W     = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_i,
  input logic              gate_i,
  input logic              valid_i,
  input logic [DATA_W-1:0] diff_i
);

  localparam int unsigned EW = $clog2(RUN_CYCLES + 2);
  localparam logic [EW-1:0] SAT = EW'(RUN_CYCLES + 1);
  localparam logic [EW-1:0] RUN = EW'(RUN_CYCLES);

  logic [EW-1:0] elapsed;

  // cycles since the last accepted start, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed <= SAT;
    end else if (!busy_i && start_i) begin
      elapsed <= '0;
    end else if (elapsed != SAT) begin
      elapsed <= elapsed + EW'(1);
    end
  end

  p_start_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && start_i) |=> busy_i);

  p_valid_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (elapsed == RUN));

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_gate_in_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |-> busy_i);

  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> (busy_i || valid_i));

  p_diff_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(diff_i));

endmodule

bind osc_diff_meter osc_diff_meter_chk #(
  .RUN_CYCLES(2*SETTLE_CYCLES + GATE_CYCLES + 2),
  .DATA_W    ((NUM_OSC-1)*DIFF_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_sys_n),
  .start_i(start_i),
  .busy_i (busy),
  .gate_i (gate_en),
  .valid_i(valid_o),
  .diff_i (diff_o)
);

// File: tb/osc_diff_meter_tb_top.sv
module osc_diff_meter_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NOSC   = 8;
  localparam int CW     = 24;
  localparam int DW     = 24;
  localparam int GATE   = 200;
  localparam int SETTLE = 16;
  localparam int RUNLEN = 2*SETTLE + GATE + 2;
  localparam real WIN_NS = GATE * 8.0;

  logic                   clk;
  logic                   rst_n;
  logic                   start;
  logic [NOSC-1:0]        osc;
  logic [(NOSC-1)*DW-1:0] diff;
  logic                   valid;

  real per [NOSC];

  int  nchk = 0;
  int  nerr = 0;
  bit  finished = 0;

  // reference model state
  int  rem = 0;
  bit  exp_valid = 0;
  logic [(NOSC-1)*DW-1:0] snap;

  osc_diff_meter #(
    .NUM_OSC(NOSC), .CNT_W(CW), .DIFF_W(DW),
    .GATE_CYCLES(GATE), .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .osc_i(osc), .diff_o(diff), .valid_o(valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  for (genvar g = 0; g < NOSC; g++) begin : g_osc
    logic o;
    initial begin
      o = 1'b0;
      #(0.31 + 0.17 * g);
      forever begin
        #(per[g] / 2.0);
        o = ~o;
      end
    end
    assign osc[g] = o;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  // cycle-by-cycle model of the run length and the valid strobe
  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0;
      exp_valid = 0;
    end else begin
      exp_valid = 0;
      if (rem > 0) begin
        rem = rem - 1;
        if (rem == 0) exp_valid = 1;
      end else if (start) begin
        rem = RUNLEN;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      snap = '0;
    end else if (!finished) begin
      check(valid == exp_valid, "R2/R3 valid strobe", longint'(valid), longint'(exp_valid));
      if (exp_valid) begin
        for (int k = 0; k < NOSC-1; k++) begin
          real e;
          int  a;
          e = WIN_NS / per[k] - WIN_NS / per[k+1];
          a = int'($signed(diff[k*DW +: DW]));
          nchk++;
          if ((real'(a) - e) > 2.0 || (e - real'(a)) > 2.0) begin
            nerr++;
            $display("FAIL R4/R5/R6 diff[%0d]: actual %0d expected %0.2f", k, a, e);
          end
        end
        snap = diff;
      end else begin
        check(diff == snap, "R8 diff hold", longint'(diff[DW-1:0]), longint'(snap[DW-1:0]));
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!exp_valid) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic set_pattern(input int which);
    for (int i = 0; i < NOSC; i++) begin
      case (which)
        0: per[i] = (i % 2 == 0) ? 4.0 + 0.35 * i : 2.6 + 0.5 * i;
        1: per[i] = 3.0 + 0.2 * i;
        default: per[i] = 4.0;
      endcase
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    set_pattern(0);
    repeat (5) @(negedge clk);
    check(valid == 1'b0, "R1 valid in reset", longint'(valid), 0);
    check(diff == '0, "R1 diff in reset", longint'(diff[DW-1:0]), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(valid == 1'b0, "R1 valid after reset", longint'(valid), 0);
    check(diff == '0, "R1 diff after reset", longint'(diff[DW-1:0]), 0);

    // R4 R5: mixed fast/slow neighbours give signs of both kinds
    pulse_start();
    wait_done();
    // R6: same pattern again must not accumulate
    pulse_start();
    wait_done();
    // monotonic periods: all differences positive
    set_pattern(1);
    pulse_start();
    wait_done();
    // R7: a second start in the middle of the gate window is ignored
    set_pattern(0);
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    wait_done();
    // R9: equal oscillators, back-to-back start in the valid cycle
    set_pattern(2);
    pulse_start();
    while (!exp_valid) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(valid == 1'b0, "R9 strobe ends", longint'(valid), 0);
    wait_done();
    repeat (10) @(negedge clk);
    finish_sim();
  end

endmodule